// File: doc/BRIEF.md
# Vector Memory Burst Address Generator

This block takes one vector memory request and turns it into a stream of AXI4 request descriptors. Each descriptor carries a start address, a beat count minus one, a beat size and a burst type. The descriptors go out on a valid/ready handshake to a downstream issue stage. A request gives a base address, an element width, a vector length in elements, an access mode and a signed byte stride.

In unit-stride mode the block packs the elements into incrementing bursts that use the full bus width. It closes a burst at every 4 KiB page boundary, so that one address translation covers the whole burst. It also closes a burst when the burst reaches 256 beats. The first beat may start unaligned. In strided mode the block issues each element as its own single-beat transaction. When the last descriptor has been taken, the block raises a one-cycle completion pulse. It accepts a new request only when it is idle.

Top module: `vec_burst_agen`

## Requirements
- R1: A request is accepted (req_valid_i and req_ready_o both high at a clock edge) only while no descriptor is pending. req_ready_o is low whenever desc_valid_o is high, and a request presented while busy does not change the descriptor stream.
- R2: In unit-stride mode (req_strided_i = 0), every descriptor has burst type INCR (desc_burst_o = 2'b01) and beat size log2(DATA_W/8). The first descriptor starts at the base address, and each following descriptor starts at the byte where the previous one ended.
- R3: No unit-stride descriptor spans a 4 KiB boundary. A transfer that would reach past one is cut at the boundary, and the next descriptor starts at the boundary address.
- R4: No descriptor carries more than 256 beats (desc_len_o at most 255). A longer transfer that stays within one page is split into several descriptors.
- R5: For an unaligned start, the beat count covers the range from the start address rounded down to the bus width up to the last byte of the descriptor, that last byte included.
- R6: In strided mode (req_strided_i = 1), element i is issued as one descriptor at address base + i*stride, where the stride is a two's-complement byte offset. Each such descriptor has desc_len_o = 0, desc_size_o = req_ew_i and burst type INCR.
- R7: Element width encoding req_ew_i: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The total transfer is req_vl_i shifted left by req_ew_i bytes.
- R8: While desc_valid_o is high and desc_ready_i is low, the descriptor stays valid and all of its fields stay unchanged in the next cycle.
- R9: done_o pulses high for exactly one cycle, in the cycle after the handshake of the last descriptor. desc_valid_o is low in that cycle.
- R10: A request with req_vl_i = 0 produces no descriptor, and done_o pulses in the cycle after the request is accepted.
- R11: After reset, desc_valid_o and done_o are low and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_base_i | input | ADDR_W | Base byte address |
| req_ew_i | input | 2 | Element width code |
| req_vl_i | input | VL_W | Vector length in elements |
| req_strided_i | input | 1 | 1 = strided, 0 = unit-stride |
| req_stride_i | input | ADDR_W | Signed byte stride (strided mode) |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor taken by the issue stage |
| desc_addr_o | output | ADDR_W | Descriptor start address |
| desc_len_o | output | 8 | Beats minus one |
| desc_size_o | output | 3 | log2 of bytes per beat |
| desc_burst_o | output | 2 | Burst type (01 = INCR) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default 64-bit bus, 32-bit addresses and a 16-bit vector length. With an 8-byte beat, 256 beats cover 2 KiB, which is less than a page. A single long unit-stride request therefore shows both the cut at the beat limit and the cut at the page boundary. Byte-wide elements at odd base addresses show the unaligned first beat. Negative strides show the address wrapping downward.

// File: rtl/vbag_pkg.sv
package vbag_pkg;
    // AXI4 burst type codes
    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10
    } burst_e;

    localparam int PAGE_BYTES = 4096;
    localparam int MAX_BEATS  = 256;
    localparam int LEN_W      = 8;
endpackage

// File: rtl/vbag_burst_calc.sv
// Unit-stride burst cutter: finds the end of the next legal burst.
module vbag_burst_calc #(
    parameter int ADDR_W    = 32,
    parameter int REM_W     = 19,
    parameter int BUS_BYTES = 8
) (
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [REM_W-1:0]            rem_i,
    output logic [vbag_pkg::LEN_W-1:0]  len_o,
    output logic [REM_W-1:0]            bytes_o
);
    localparam int EXT_W = ADDR_W + 1;
    localparam int OFF_W = $clog2(BUS_BYTES);
    localparam int PG_W  = $clog2(vbag_pkg::PAGE_BYTES);
    localparam int CAP   = vbag_pkg::MAX_BEATS * BUS_BYTES;

    logic [EXT_W-1:0] a_x, al_x, end_x, page_x, cap_x, lim_x, span_x;

    always_comb begin
        a_x    = {1'b0, addr_i};
        al_x   = {a_x[EXT_W-1:OFF_W], {OFF_W{1'b0}}};
        end_x  = a_x + EXT_W'(rem_i);
        page_x = {a_x[EXT_W-1:PG_W], {PG_W{1'b0}}} + EXT_W'(vbag_pkg::PAGE_BYTES);
        cap_x  = al_x + EXT_W'(CAP);
        lim_x  = end_x;
        if (page_x < lim_x) lim_x = page_x;
        if (cap_x < lim_x)  lim_x = cap_x;
        // inclusive last byte, measured from the aligned start
        span_x  = (lim_x - EXT_W'(1)) - al_x;
        len_o   = vbag_pkg::LEN_W'(span_x >> OFF_W);
        bytes_o = REM_W'(lim_x - a_x);
    end
endmodule

// File: rtl/vbag_stride_calc.sv
// Strided step: address of the next element and bytes of one element.
module vbag_stride_calc #(
    parameter int ADDR_W = 32,
    parameter int REM_W  = 19
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [1:0]        ew_i,
    output logic [ADDR_W-1:0] next_o,
    output logic [REM_W-1:0]  bytes_o
);
    always_comb begin
        next_o  = addr_i + stride_i;
        bytes_o = REM_W'(1) << ew_i;
    end
endmodule

// File: rtl/vec_burst_agen.sv
module vec_burst_agen #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int VL_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid_i,
    output logic                        req_ready_o,
    input  logic [ADDR_W-1:0]           req_base_i,
    input  logic [1:0]                  req_ew_i,
    input  logic [VL_W-1:0]             req_vl_i,
    input  logic                        req_strided_i,
    input  logic [ADDR_W-1:0]           req_stride_i,
    output logic                        desc_valid_o,
    input  logic                        desc_ready_i,
    output logic [ADDR_W-1:0]           desc_addr_o,
    output logic [vbag_pkg::LEN_W-1:0]  desc_len_o,
    output logic [2:0]                  desc_size_o,
    output logic [1:0]                  desc_burst_o,
    output logic                        done_o
);
    localparam int BUS_BYTES = DATA_W / 8;
    localparam int OFF_W     = $clog2(BUS_BYTES);
    localparam int REM_W     = VL_W + 3;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              strided;
        logic [1:0]        ew;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
        logic [REM_W-1:0]  rem;
    } agen_st_t;

    agen_st_t s_d, s_q;

    logic [vbag_pkg::LEN_W-1:0] u_len;
    logic [REM_W-1:0]           u_bytes, e_bytes, step;
    logic [ADDR_W-1:0]          e_next;

    vbag_burst_calc #(
        .ADDR_W   (ADDR_W),
        .REM_W    (REM_W),
        .BUS_BYTES(BUS_BYTES)
    ) u_burst (
        .addr_i (s_q.addr),
        .rem_i  (s_q.rem),
        .len_o  (u_len),
        .bytes_o(u_bytes)
    );

    vbag_stride_calc #(
        .ADDR_W(ADDR_W),
        .REM_W (REM_W)
    ) u_stride (
        .addr_i  (s_q.addr),
        .stride_i(s_q.stride),
        .ew_i    (s_q.ew),
        .next_o  (e_next),
        .bytes_o (e_bytes)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        step     = s_q.strided ? e_bytes : u_bytes;
        if (!s_q.busy) begin
            if (req_valid_i) begin
                s_d.addr    = req_base_i;
                s_d.ew      = req_ew_i;
                s_d.strided = req_strided_i;
                s_d.stride  = req_stride_i;
                s_d.rem     = REM_W'(req_vl_i) << req_ew_i;
                if (req_vl_i == '0) s_d.done = 1'b1;
                else                s_d.busy = 1'b1;
            end
        end else if (desc_ready_i) begin
            s_d.rem  = s_q.rem - step;
            s_d.addr = s_q.strided ? e_next : s_q.addr + ADDR_W'(u_bytes);
            if (s_q.rem == step) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        req_ready_o  = !s_q.busy;
        desc_valid_o = s_q.busy;
        desc_addr_o  = s_q.addr;
        desc_len_o   = s_q.strided ? '0 : u_len;
        desc_size_o  = s_q.strided ? {1'b0, s_q.ew} : 3'(OFF_W);
        desc_burst_o = vbag_pkg::BT_INCR;
        done_o       = s_q.done;
    end
endmodule

// File: rtl/vbag_chk.sv
module vbag_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int VL_W   = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid_i,
    input logic                        req_ready_o,
    input logic                        desc_valid_o,
    input logic                        desc_ready_i,
    input logic [ADDR_W-1:0]           desc_addr_o,
    input logic [vbag_pkg::LEN_W-1:0]  desc_len_o,
    input logic [2:0]                  desc_size_o,
    input logic                        done_o
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int PG_W  = $clog2(vbag_pkg::PAGE_BYTES);

    logic [ADDR_W:0] first_beat, last_beat;
    always_comb begin
        first_beat = ({1'b0, desc_addr_o} >> desc_size_o) << desc_size_o;
        last_beat  = first_beat + ((ADDR_W+1)'(desc_len_o) << desc_size_o);
    end

    // R1
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_valid_o) |-> $past(req_valid_i && req_ready_o));

    // R3
    page_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (first_beat[ADDR_W:PG_W] == last_beat[ADDR_W:PG_W]));

    // R8
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && !desc_ready_i) |=> (desc_valid_o && $stable(desc_addr_o)
            && $stable(desc_len_o) && $stable(desc_size_o)));

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(desc_valid_o && desc_ready_i) || $past(req_valid_i && req_ready_o)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !desc_valid_o);

    // R2
    size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (desc_size_o <= 3'(OFF_W)));
endmodule

bind vec_burst_agen vbag_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .VL_W  (VL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .desc_valid_o(desc_valid_o),
    .desc_ready_i(desc_ready_i),
    .desc_addr_o (desc_addr_o),
    .desc_len_o  (desc_len_o),
    .desc_size_o (desc_size_o),
    .done_o      (done_o)
);

// File: tb/vec_burst_agen_tb.sv
module vec_burst_agen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_base_i = '0;
    logic [1:0]  req_ew_i = '0;
    logic [15:0] req_vl_i = '0;
    logic        req_strided_i = 1'b0;
    logic [31:0] req_stride_i = '0;
    logic        desc_valid_o;
    logic        desc_ready_i = 1'b0;
    logic [31:0] desc_addr_o;
    logic [7:0]  desc_len_o;
    logic [2:0]  desc_size_o;
    logic [1:0]  desc_burst_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vec_burst_agen u_dut (.*);

    task automatic check(input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", what);
        end
    endtask

    // Reference burst: walk beat by beat from the aligned start.
    task automatic ref_burst(input logic [32:0] a, input int rem,
                             output int len, output int bytes);
        logic [32:0] e, nxt;
        int beats;
        e = a + 33'(rem);
        nxt = {a[32:3], 3'b000} + 33'd8;
        beats = 1;
        while (nxt < e && nxt[11:0] != 12'h000 && beats < 256) begin
            beats++;
            nxt += 33'd8;
        end
        len = beats - 1;
        bytes = int'(((nxt < e) ? nxt : e) - a);
    endtask

    task automatic run_req(input string tag, input logic [31:0] base, input logic [1:0] ew,
                           input int vl, input bit strided, input logic [31:0] stride,
                           input bit stall);
        logic [31:0] r_addr, h_addr;
        logic [7:0]  h_len;
        logic [2:0]  h_size;
        int rem, guard, e_len, e_bytes, n_desc;
        bit held;
        @(negedge clk);
        req_base_i = base; req_ew_i = ew; req_vl_i = 16'(vl);
        req_strided_i = strided; req_stride_i = stride; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        r_addr = base; rem = vl << ew; guard = 0; held = 0; n_desc = 0;
        while (rem > 0 && guard < 20000) begin
            desc_ready_i = stall ? (guard % 3 != 0) : 1'b1;
            #1;
            if (held)  // R8
                check(desc_valid_o && desc_addr_o == h_addr && desc_len_o == h_len
                      && desc_size_o == h_size,
                      $sformatf("R8 %s hold: got %h/%0d/%0d exp %h/%0d/%0d", tag,
                                desc_addr_o, desc_len_o, desc_size_o, h_addr, h_len, h_size));
            held = 0;
            if (desc_valid_o && desc_ready_i) begin
                if (strided) begin
                    e_len = 0; e_bytes = 1 << ew;
                end else begin
                    ref_burst({1'b0, r_addr}, rem, e_len, e_bytes);
                end
                check(desc_addr_o == r_addr && int'(desc_len_o) == e_len
                      && desc_size_o == (strided ? {1'b0, ew} : 3'd3) && desc_burst_o == 2'b01,
                      $sformatf("%s desc %0d: got %h/%0d/%0d/%0d exp %h/%0d/%0d/1", tag, n_desc,
                                desc_addr_o, desc_len_o, desc_size_o, desc_burst_o, r_addr, e_len,
                                strided ? {1'b0, ew} : 3'd3));
                r_addr = strided ? r_addr + stride : r_addr + 32'(e_bytes);
                rem -= e_bytes;
                n_desc++;
            end else if (desc_valid_o) begin
                held = 1; h_addr = desc_addr_o; h_len = desc_len_o; h_size = desc_size_o;
            end
            @(negedge clk);
            guard++;
        end
        desc_ready_i = 1'b0;
        // R9 R10
        check(done_o && !desc_valid_o,
              $sformatf("R9 %s done after last: got done=%0b valid=%0b exp 1/0", tag, done_o, desc_valid_o));
        @(negedge clk);
        check(!done_o, $sformatf("R9 %s done width: got %0b exp 0", tag, done_o));
    endtask

    // R1: a second request offered while busy is refused and ignored
    task automatic busy_refuse();
        @(negedge clk);
        req_base_i = 32'h100; req_ew_i = 2'd3; req_vl_i = 16'd2;
        req_strided_i = 1'b1; req_stride_i = 32'd8; req_valid_i = 1'b1;
        @(negedge clk);
        req_base_i = 32'h9000; req_stride_i = 32'd64; req_vl_i = 16'd7;
        for (int k = 0; k < 3; k++) begin
            check(!req_ready_o && desc_valid_o && desc_addr_o == 32'h100,
                  $sformatf("R1 busy refuse: got ready=%0b addr=%h exp 0/00000100", req_ready_o, desc_addr_o));
            @(negedge clk);
        end
        req_valid_i = 1'b0;
        desc_ready_i = 1'b1;
        #1;
        check(desc_addr_o == 32'h100, $sformatf("R1 first elem: got %h exp 00000100", desc_addr_o));
        @(negedge clk);
        check(desc_valid_o && desc_addr_o == 32'h108,
              $sformatf("R1 second elem: got %h exp 00000108", desc_addr_o));
        @(negedge clk);
        desc_ready_i = 1'b0;
        check(done_o && !desc_valid_o && req_ready_o,
              $sformatf("R1 end: got done=%0b valid=%0b exp 1/0", done_o, desc_valid_o));
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11
        check(!desc_valid_o && !done_o && req_ready_o,
              $sformatf("R11 reset: got v=%0b d=%0b r=%0b exp 0/0/1", desc_valid_o, done_o, req_ready_o));
        rst_n = 1'b1;
        @(negedge clk);
        run_req("R2 R7 aligned", 32'h1000, 2'd3, 4, 1'b0, 32'd0, 1'b0);
        run_req("R5 unaligned", 32'h1003, 2'd0, 10, 1'b0, 32'd0, 1'b0);
        run_req("R5 R7 odd halfwords", 32'h0207, 2'd1, 13, 1'b0, 32'd0, 1'b1);
        run_req("R3 page cut", 32'h1FF0, 2'd2, 8, 1'b0, 32'd0, 1'b0);
        run_req("R4 R3 long", 32'h0000_0000, 2'd3, 600, 1'b0, 32'd0, 1'b1);
        run_req("R4 R3 long unaligned", 32'h0003_0805, 2'd0, 5000, 1'b0, 32'd0, 1'b0);
        run_req("R6 stride up", 32'h4000, 2'd2, 5, 1'b1, 32'd24, 1'b0);
        run_req("R6 stride down", 32'h10, 2'd1, 3, 1'b1, 32'hFFFF_FFF0, 1'b1);
        run_req("R10 empty", 32'h5000, 2'd3, 0, 1'b0, 32'd0, 1'b0);
        busy_refuse();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule